// File: doc/BRIEF.md
# Per-Subpage ECC Status Evaluator

After a page read, an error-correcting decoder leaves a packed status word behind. That word holds one small error-count field for every 512-byte subpage of the page. This block reads such a word. It adds up the number of corrected symbols across the page, or it reports that the page could not be repaired. A mode input picks between the light correction strength and the strong one. The light strength is meant for every spare-area size except the 218-byte layout, which uses the strong strength.

A one-cycle start pulse captures three inputs: the status word, the mode and the page size in bytes. The block then looks at one subpage field per clock, beginning with subpage 0. It stops early at the first field that exceeds the mode's limit. When it finishes, it updates the corrected total and the uncorrectable flag and raises a one-cycle done pulse. Both results hold their values until the next evaluation finishes.

Top module: `ecc_status_eval`

## Requirements
- R1: After reset, doneOut, uncorrOut and totalOut are all 0.
- R2: The field for subpage i sits at status bits [4i+3:4i]. Subpage 0 is the lowest nibble, and fields are visited in rising subpage order.
- R3: With eightSymIn = 0 (4-symbol mode), only the low 3 bits of a field count. A masked value above 4 is uncorrectable.
- R4: With eightSymIn = 1 (8-symbol mode), all 4 bits of a field count. A value above 8 is uncorrectable.
- R5: The number of fields examined is pageBytesIn / 512, rounded down. A result of 0 is treated as 1 and a result above 4 is treated as 4. Fields beyond that count have no effect.
- R6: When no examined field exceeds the limit, uncorrOut = 0 and totalOut equals the sum of the examined field values.
- R7: When an examined field exceeds the limit, uncorrOut = 1 and totalOut = 0. Examination stops at the first such field.
- R8: doneOut is high for exactly one cycle. It rises k clock edges after the edge that sampled startIn, where k is the position of the stopping field (counting from 1).
- R9: A startIn pulse that arrives while an evaluation is running is ignored.
- R10: totalOut and uncorrOut keep their values between completions, whatever the inputs do.
- R11: A startIn pulse sampled in the same cycle that doneOut is high begins a new evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start pulse; captures the three inputs below |
| statusIn | input | 16 | Packed per-subpage error counts |
| eightSymIn | input | 1 | 1 selects 8-symbol mode, 0 selects 4-symbol mode |
| pageBytesIn | input | 14 | Page size in bytes |
| totalOut | output | 6 | Corrected-symbol total for the page |
| uncorrOut | output | 1 | Page could not be corrected |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the done pulse of one evaluation and the start of the next. The bench provokes this by raising startIn in the very cycle it first sees doneOut high. The checks are that done drops on the next edge, that the new evaluation finishes after its own latency, and that it reports its own total rather than anything left from the earlier run. The bench also sweeps every combination of the two lowest fields, across both modes and six page sizes, against a totalling model written directly from the requirements.

// File: rtl/eccstat_pkg.sv
`timescale 1ns/1ps
package eccstat_pkg;
  typedef struct packed {
    logic load;    // capture inputs, clear accumulator
    logic step;    // add current field, advance to next
    logic finish;  // last or failing field: publish results
  } scanStb_t;
endpackage

// File: rtl/eccstat_datapath.sv
`timescale 1ns/1ps
module eccstat_datapath
  import eccstat_pkg::*;
#(
  parameter int FIELD_W      = 4,
  parameter int MAX_SUBPAGES = 4,
  parameter int LIMIT_LO     = 4,
  parameter int LIMIT_HI     = 8,
  parameter int SUM_W        = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  scanStb_t                        stb,
  input  logic [FIELD_W*MAX_SUBPAGES-1:0] statusIn,
  input  logic                            eightSymIn,
  output logic                            fieldBad,
  output logic [SUM_W-1:0]                totalOut,
  output logic                            uncorrOut
);
  localparam int STATUS_W = FIELD_W * MAX_SUBPAGES;
  localparam logic [FIELD_W-1:0] LIM_LO = FIELD_W'(LIMIT_LO);
  localparam logic [FIELD_W-1:0] LIM_HI = FIELD_W'(LIMIT_HI);
  localparam int HI_BOUND = LIMIT_HI * MAX_SUBPAGES;

  logic [STATUS_W-1:0] shiftReg;
  logic                modeReg;
  logic [SUM_W-1:0]    accReg;
  logic [FIELD_W-1:0]  fieldRaw;
  logic [FIELD_W-1:0]  fieldVal;
  logic [FIELD_W-1:0]  limitVal;
  logic [SUM_W-1:0]    accNext;

  always_comb begin
    fieldRaw = shiftReg[FIELD_W-1:0];
    fieldVal = modeReg ? fieldRaw : {1'b0, fieldRaw[FIELD_W-2:0]};
    limitVal = modeReg ? LIM_HI : LIM_LO;
    fieldBad = fieldVal > limitVal;
    accNext  = accReg + SUM_W'(fieldVal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      modeReg   <= 1'b0;
      accReg    <= '0;
      totalOut  <= '0;
      uncorrOut <= 1'b0;
    end else begin
      if (stb.load) begin
        shiftReg <= statusIn;
        modeReg  <= eightSymIn;
        accReg   <= '0;
      end else if (stb.step) begin
        shiftReg <= shiftReg >> FIELD_W;
        accReg   <= accNext;
      end
      if (stb.finish) begin
        totalOut  <= fieldBad ? '0 : accNext;
        uncorrOut <= fieldBad;
      end
    end
  end

  // R7: a failing page never carries a nonzero total
  assert_bad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finish |=> (!uncorrOut || totalOut == '0));
  // R6: a clean total stays within the strongest mode's bound
  assert_total_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finish |=> (uncorrOut || int'(totalOut) <= HI_BOUND));
  // R9: mode cannot change while a scan is stepping
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |=> $stable(modeReg));
  // R10: results move only on completion
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.finish |=> ($stable(totalOut) && $stable(uncorrOut)));
endmodule

// File: rtl/eccstat_control.sv
`timescale 1ns/1ps
module eccstat_control
  import eccstat_pkg::*;
#(
  parameter int MAX_SUBPAGES  = 4,
  parameter int PAGE_W        = 14,
  parameter int SUBPAGE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startIn,
  input  logic [PAGE_W-1:0] pageBytesIn,
  input  logic              fieldBad,
  output scanStb_t          stb,
  output logic              doneOut
);
  localparam int IDX_W = $clog2(MAX_SUBPAGES + 1);
  localparam logic [PAGE_W-1:0] MAX_P = PAGE_W'(MAX_SUBPAGES);

  typedef enum logic {ST_IDLE, ST_SCAN} scanState_t;

  scanState_t        state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  lastIdx;
  logic [IDX_W-1:0]  lastIdxIn;
  logic [PAGE_W-1:0] rawCount;
  logic              atLast;

  always_comb begin
    rawCount = pageBytesIn >> SUBPAGE_SHIFT;
    if (rawCount == '0)
      lastIdxIn = '0;
    else if (rawCount > MAX_P)
      lastIdxIn = IDX_W'(MAX_SUBPAGES - 1);
    else
      lastIdxIn = IDX_W'(rawCount - PAGE_W'(1));
    atLast     = idx == lastIdx;
    stb.load   = (state == ST_IDLE) && startIn;
    stb.finish = (state == ST_SCAN) && (fieldBad || atLast);
    stb.step   = (state == ST_SCAN) && !stb.finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= stb.finish;
      if (stb.load) begin
        state   <= ST_SCAN;
        idx     <= '0;
        lastIdx <= lastIdxIn;
      end else if (stb.finish) begin
        state <= ST_IDLE;
      end else if (stb.step) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R8: completion pulse lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);
  // R5: the walk never passes the clamped field count
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN) |-> (idx <= lastIdx && int'(lastIdx) < MAX_SUBPAGES));
  // R9: a running scan keeps running or finishes, whatever startIn does
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && startIn && !stb.finish) |=> (state == ST_SCAN && !doneOut));
endmodule

// File: rtl/ecc_status_eval.sv
`timescale 1ns/1ps
module ecc_status_eval
  import eccstat_pkg::*;
#(
  parameter int FIELD_W       = 4,
  parameter int MAX_SUBPAGES  = 4,
  parameter int LIMIT_LO      = 4,
  parameter int LIMIT_HI      = 8,
  parameter int PAGE_W        = 14,
  parameter int SUBPAGE_SHIFT = 9,
  localparam int STATUS_W     = FIELD_W * MAX_SUBPAGES,
  localparam int SUM_W        = $clog2(MAX_SUBPAGES * ((1 << FIELD_W) - 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startIn,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic                eightSymIn,
  input  logic [PAGE_W-1:0]   pageBytesIn,
  output logic [SUM_W-1:0]    totalOut,
  output logic                uncorrOut,
  output logic                doneOut
);
  scanStb_t stb;
  logic     fieldBad;

  eccstat_control #(
    .MAX_SUBPAGES (MAX_SUBPAGES),
    .PAGE_W       (PAGE_W),
    .SUBPAGE_SHIFT(SUBPAGE_SHIFT)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startIn    (startIn),
    .pageBytesIn(pageBytesIn),
    .fieldBad   (fieldBad),
    .stb        (stb),
    .doneOut    (doneOut)
  );

  eccstat_datapath #(
    .FIELD_W     (FIELD_W),
    .MAX_SUBPAGES(MAX_SUBPAGES),
    .LIMIT_LO    (LIMIT_LO),
    .LIMIT_HI    (LIMIT_HI),
    .SUM_W       (SUM_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .statusIn  (statusIn),
    .eightSymIn(eightSymIn),
    .fieldBad  (fieldBad),
    .totalOut  (totalOut),
    .uncorrOut (uncorrOut)
  );
endmodule

// File: tb/sim_ecc_status_eval.sv
`timescale 1ns/1ps
module sim_ecc_status_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startIn = 1'b0;
  logic [15:0] statusIn = '0;
  logic        eightSymIn = 1'b0;
  logic [13:0] pageBytesIn = '0;
  logic [5:0]  totalOut;
  logic        uncorrOut;
  logic        doneOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ecc_status_eval u0 (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .statusIn(statusIn),
    .eightSymIn(eightSymIn), .pageBytesIn(pageBytesIn),
    .totalOut(totalOut), .uncorrOut(uncorrOut), .doneOut(doneOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model from R2..R7: expected total, flag and latency
  task automatic model(input logic [15:0] s, input bit m, input int pb,
                       output int tot, output bit bad, output int lat);
    int n = pb / 512;
    if (n == 0) n = 1;
    if (n > 4) n = 4;
    tot = 0; bad = 0; lat = n;
    for (int i = 0; i < n; i++) begin
      int f = (s >> (4 * i)) & (m ? 15 : 7);
      if (f > (m ? 8 : 4)) begin
        bad = 1; tot = 0; lat = i + 1;
        break;
      end
      tot += f;
    end
  endtask

  task automatic launch(input logic [15:0] s, input bit m, input int pb);
    @(negedge clk);
    statusIn = s; eightSymIn = m; pageBytesIn = 14'(pb); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!doneOut && lat < 40);
  endtask

  task automatic runOne(input logic [15:0] s, input bit m, input int pb, input string req);
    int eTot, eLat, lat;
    bit eBad;
    model(s, m, pb, eTot, eBad, eLat);
    launch(s, m, pb);
    waitDone(lat);
    chk(lat == eLat, {req, " latency R8"}, lat, eLat);
    chk(int'(totalOut) == eTot, {req, " total"}, int'(totalOut), eTot);
    chk(uncorrOut == eBad, {req, " flag"}, int'(uncorrOut), int'(eBad));
    @(posedge clk); #1;
    chk(!doneOut, "R8 done single cycle", int'(doneOut), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, pulses;
    logic [5:0] holdT;
    logic holdU;
    repeat (3) @(posedge clk);
    #1;
    chk(!doneOut, "R1 done", int'(doneOut), 0);
    chk(!uncorrOut, "R1 flag", int'(uncorrOut), 0);
    chk(totalOut == 0, "R1 total", int'(totalOut), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 field placement and order
    runOne(16'h0001, 1, 2048, "R2 low nibble");
    runOne(16'h1000, 1, 2048, "R2 top nibble");
    runOne(16'h0090, 1, 2048, "R2 stop at subpage1");
    runOne(16'h9000, 1, 2048, "R2 stop at subpage3");
    // R3 4-symbol mode masking and limit
    runOne(16'h000F, 0, 2048, "R3 masked 7 fails");
    runOne(16'h0008, 0, 2048, "R3 masked to 0");
    runOne(16'h4444, 0, 2048, "R3 at limit");
    runOne(16'h0005, 0, 512,  "R3 just over limit");
    // R4 8-symbol mode
    runOne(16'h8888, 1, 2048, "R4 at limit");
    runOne(16'h0009, 1, 512,  "R4 just over limit");
    // R5 page size clamping
    runOne(16'hFFF1, 0, 0,    "R5 size zero");
    runOne(16'hFFF2, 1, 1023, "R5 one field");
    runOne(16'h3333, 0, 4096, "R5 clamp to four");
    runOne(16'hF021, 1, 1536, "R5 top field ignored");
    // R7 uncorrectable on last field: both stop causes in one cycle
    runOne(16'hA111, 1, 2048, "R7 last field bad");

    // R6/R7/R8 sweep: both modes, six sizes, all 256 low-field pairs
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 6; c++)
        for (int v = 0; v < 256; v++) begin
          logic [7:0] vb = 8'(v);
          runOne({vb ^ 8'hA5, vb}, bit'(m), (c == 5) ? 4096 : c * 512, "R6 R7 sweep");
        end

    // R9 start during a running scan is ignored
    launch(16'h2222, 1, 2048);
    @(negedge clk);
    statusIn = 16'hFFFF; eightSymIn = 1'b0; pageBytesIn = 14'd512; startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (doneOut) begin
        pulses++;
        chk(totalOut == 8, "R9 total kept", int'(totalOut), 8);
        chk(!uncorrOut, "R9 flag kept", int'(uncorrOut), 0);
      end
    end
    chk(pulses == 1, "R9 single completion", pulses, 1);

    // R10 outputs hold while inputs wander
    holdT = totalOut; holdU = uncorrOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      statusIn = 16'(i * 16'h1357); eightSymIn = i[0]; pageBytesIn = 14'(i * 700);
    end
    @(posedge clk); #1;
    chk(totalOut == holdT, "R10 total held", int'(totalOut), int'(holdT));
    chk(uncorrOut == holdU, "R10 flag held", int'(uncorrOut), int'(holdU));

    // R11 start in the done cycle
    launch(16'h0003, 1, 512);
    waitDone(lat);
    chk(lat == 1 && totalOut == 3, "R11 first run", int'(totalOut), 3);
    @(negedge clk);
    statusIn = 16'h0045; eightSymIn = 1'b1; pageBytesIn = 14'd1024; startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    #1;
    chk(!doneOut, "R11 done dropped", int'(doneOut), 0);
    waitDone(lat);
    chk(lat == 2, "R11 second latency", lat, 2);
    chk(totalOut == 9, "R11 second total", int'(totalOut), 9);
    chk(!uncorrOut, "R11 second flag", int'(uncorrOut), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule